// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the write-command state machine of a parallel NOR flash device, placed behind a plain synchronous memory bus. A host issues byte-addressed reads and writes. The block turns each byte address into a word address for the configured bus width. It then walks the address-qualified unlock handshake and decodes the command that follows. From that it chooses what a read returns: array data, identification words, bytes of the query table, or a status byte while a program runs.

The storage array sits outside the block and is reached through a simple word port with an asynchronous read. A program is a single-cycle read-modify-write, so a program can only clear bits. Erase timing is not part of this block. The block only recognises the erase command sequences and signals a separate erase scheduler through one-cycle strobes. It takes back a single busy level from that scheduler.

The bus stays strobe-based rather than valid/ready. Every access completes in a fixed time and there is no back-pressure: a read answers one cycle later with `rd_valid`, and a write is taken on the edge where `bus_wr` is high. The host must not assert `bus_rd` and `bus_wr` in the same cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: The word address is the byte address shifted right by 0, 1 or 2 for an 8-, 16- or 32-bit bus. Command decoding uses only the low 11 bits of the word address. In array-read mode, a read returns the array word at that word address on `rd_data`, with `rd_valid` high, one cycle after `bus_rd`.
- R2: An unlock needs two writes. The first writes 0xAA (low data byte) to word UNLOCK0, and the second writes 0x55 to word UNLOCK1. Any mismatch returns the sequencer to idle with bypass cleared, so the writes that follow do not program.
- R3: The command write after an unlock must target UNLOCK0, unless bypass is active. Its low byte selects the command: 0x20 bypass, 0x80 erase setup, 0x90 ID read, 0xA0 program. Any other value resets the sequencer to idle.
- R4: In program mode, the next write stores (old word AND write data) at its word address, so a bit can only go from 1 to 0. The program then runs for BUSY_CYCLES cycles. After that the sequencer goes back to idle, or to the command state if bypass is active.
- R5: In ID mode, word 0 reads ID0, word 1 reads ID1 and word 2 reads 0. Word 0x00E reads ID2 and word 0x00F reads ID3, unless that ID equals 0x00FF, in which case the read returns array data. Every other decoded word reads array data.
- R6: Command 0x20 sets bypass. In bypass, a program needs only 0xA0 at any address followed by the data write. Writing 0x00 while in ID mode with bypass active clears bypass and returns to array read.
- R7: Writing 0x98 to word 0x055 from idle or from ID mode enters query mode. Reads then return a byte indexed by the decoded word: 0x010, 0x011 and 0x012 give 0x51, 0x52 and 0x59; 0x013 gives 0x02; 0x027 gives ADDR_W. Every other index, and every index at or above QRY_LEN, gives 0.
- R8: While a program is busy, reads return a status byte in bits 7:0, with all other bits 0. Bit 7 is the complement of data bit 7. Bit 6 reads 1 on the first read and then inverts on each later read. Writes during this time are ignored.
- R9: 0xF0 returns to array read with bypass cleared. It has no such effect when it is the program data write, where it is stored as data. When query mode was entered from ID mode, 0xF0 goes back to ID mode instead.
- R10: Any write other than 0xF0 in query mode returns the sequencer to idle and array read.
- R11: After 0x80, a second unlock followed by 0x30 at any address pulses `ers_sect_go` for one cycle, with `ers_addr` set to that word address. 0x10 at UNLOCK0 pulses `ers_chip_go` for one cycle instead. 0x10 at any other address resets the sequencer with no pulse.
- R12: While `ers_busy` is high, 0xF0 is ignored and the sequencer keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8*BUS_BYTES | Write data; the command is in the low byte |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8*BUS_BYTES | Read result, registered |
| rd_valid | output | 1 | High one cycle after `bus_rd` |
| arr_addr | output | ADDR_W-log2(BUS_BYTES) | Word address to the storage array |
| arr_rdata | input | 8*BUS_BYTES | Asynchronous read data from the array |
| arr_we | output | 1 | Array write enable |
| arr_wdata | output | 8*BUS_BYTES | Array write data (old AND new) |
| ers_busy | input | 1 | Erase scheduler reports an erase in progress |
| ers_chip_go | output | 1 | One-cycle chip erase request |
| ers_sect_go | output | 1 | One-cycle sector erase request |
| ers_addr | output | ADDR_W-log2(BUS_BYTES) | Word address captured with the erase request |

## Verification
The bench programs a sweep of words with data patterns that clear a different bit set each time. It also reprograms a word with all ones, which shows that programming clears bits and never sets them. The unlock is broken at each of its four points: wrong first address, wrong first data, wrong second address and wrong second data. After each break the bench proves that no later write reaches the array. The ID and query windows are swept word by word, including aliases above bit 10 and indices past the table end, which separates address masking from table lookup. Bypass, the 0xF0 exit paths, erase strobes and the erase-busy guard are each run so that a correct and an altered sequencer lead to different array contents or pulse counts.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_CMD,
    ST_PROG,
    ST_BUSY,
    ST_ID,
    ST_QRY,
    ST_QRY_ID,
    ST_ER_UNL0,
    ST_ER_UNL1,
    ST_ER_CMD
  } seq_state_e;

  localparam int DEC_W = 11;

  localparam logic [7:0] C_UNLOCK_A = 8'hAA;
  localparam logic [7:0] C_UNLOCK_B = 8'h55;
  localparam logic [7:0] C_BYPASS   = 8'h20;
  localparam logic [7:0] C_ERASE    = 8'h80;
  localparam logic [7:0] C_IDREAD   = 8'h90;
  localparam logic [7:0] C_PROG     = 8'hA0;
  localparam logic [7:0] C_QUERY    = 8'h98;
  localparam logic [7:0] C_EXIT     = 8'hF0;
  localparam logic [7:0] C_CHIP     = 8'h10;
  localparam logic [7:0] C_SECT     = 8'h30;
  localparam logic [7:0] C_BYP_OFF  = 8'h00;

  localparam logic [DEC_W-1:0] QUERY_WADDR = 11'h055;

  // Query table content, computed from the index.
  function automatic logic [7:0] query_byte(input logic [DEC_W-1:0] idx,
                                            input int tab_len,
                                            input int size_log2);
    logic [7:0] b;
    b = 8'h00;
    if (int'(idx) < tab_len) begin
      case (idx)
        11'h010: b = 8'h51;
        11'h011: b = 8'h52;
        11'h012: b = 8'h59;
        11'h013: b = 8'h02;
        11'h027: b = size_log2[7:0];
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/nor_addr_decode.sv
module nor_addr_decode #(
  parameter int ADDR_W  = 13,
  parameter int SHIFT   = 1,
  parameter int WADDR_W = 12
) (
  input  logic [ADDR_W-1:0]  byte_addr,
  output logic [WADDR_W-1:0] word_addr,
  output logic [10:0]        dec_addr
);

  generate
    if (SHIFT == 0) begin : g_byte_bus
      assign word_addr = byte_addr;
    end else begin : g_wide_bus
      assign word_addr = byte_addr[ADDR_W-1:SHIFT];
    end

    if (WADDR_W >= 11) begin : g_mask
      assign dec_addr = word_addr[10:0];
    end else begin : g_pad
      assign dec_addr = {{(11-WADDR_W){1'b0}}, word_addr};
    end
  endgenerate

endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          WADDR_W     = 12,
  parameter logic [10:0] UNL0        = 11'h555,
  parameter logic [10:0] UNL1        = 11'h2AA,
  parameter int          BUSY_CYCLES = 6,
  parameter int          CNT_W       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      wdata,
  input  logic [10:0]        dec_addr,
  input  logic [WADDR_W-1:0] word_addr,
  input  logic [DW-1:0]      arr_rdata,
  input  logic               ers_busy,
  output seq_state_e         state,
  output logic               bypass,
  output logic               status_b7,
  output logic               status_b6,
  output logic               arr_we,
  output logic [DW-1:0]      arr_wdata,
  output logic               ers_chip_go,
  output logic               ers_sect_go,
  output logic [WADDR_W-1:0] ers_addr
);

  logic [7:0]       cmd;
  seq_state_e       nxt_state;
  logic             nxt_bypass;
  logic             go_reset;
  logic             chip_n;
  logic             sect_n;
  logic [CNT_W-1:0] busy_cnt;
  seq_state_e       ret_state;

  assign cmd       = wdata[7:0];
  assign arr_we    = bus_wr && (state == ST_PROG);
  assign arr_wdata = arr_rdata & wdata;
  assign ret_state = bypass ? ST_CMD : ST_IDLE;

  always_comb begin
    nxt_state  = state;
    nxt_bypass = bypass;
    go_reset   = 1'b0;
    chip_n     = 1'b0;
    sect_n     = 1'b0;
    if (bus_wr) begin
      if (state == ST_PROG) begin
        nxt_state = ST_BUSY;
      end else if (state == ST_BUSY) begin
        nxt_state = state;
      end else if (cmd == C_EXIT) begin
        if (!ers_busy) begin
          if (state == ST_QRY_ID) nxt_state = ST_ID;
          else                    go_reset  = 1'b1;
        end
      end else begin
        case (state)
          ST_IDLE: begin
            if (dec_addr == QUERY_WADDR && cmd == C_QUERY) nxt_state = ST_QRY;
            else if (dec_addr == UNL0 && cmd == C_UNLOCK_A) nxt_state = ST_UNL1;
            else go_reset = 1'b1;
          end
          ST_UNL1: begin
            if (dec_addr == UNL1 && cmd == C_UNLOCK_B) nxt_state = ST_CMD;
            else go_reset = 1'b1;
          end
          ST_CMD: begin
            if (!bypass && dec_addr != UNL0) begin
              go_reset = 1'b1;
            end else begin
              case (cmd)
                C_BYPASS: nxt_bypass = 1'b1;
                C_ERASE:  nxt_state  = ST_ER_UNL0;
                C_IDREAD: nxt_state  = ST_ID;
                C_PROG:   nxt_state  = ST_PROG;
                default:  go_reset   = 1'b1;
              endcase
            end
          end
          ST_ID: begin
            if (bypass && cmd == C_BYP_OFF) go_reset = 1'b1;
            else if (dec_addr == QUERY_WADDR && cmd == C_QUERY) nxt_state = ST_QRY_ID;
            else go_reset = 1'b1;
          end
          ST_ER_UNL0: begin
            if (dec_addr == UNL0 && cmd == C_UNLOCK_A) nxt_state = ST_ER_UNL1;
            else go_reset = 1'b1;
          end
          ST_ER_UNL1: begin
            if (dec_addr == UNL1 && cmd == C_UNLOCK_B) nxt_state = ST_ER_CMD;
            else go_reset = 1'b1;
          end
          ST_ER_CMD: begin
            if (cmd == C_CHIP && dec_addr == UNL0) begin
              chip_n    = 1'b1;
              nxt_state = ret_state;
            end else if (cmd == C_SECT) begin
              sect_n    = 1'b1;
              nxt_state = ret_state;
            end else begin
              go_reset = 1'b1;
            end
          end
          default: go_reset = 1'b1;
        endcase
      end
      if (go_reset) begin
        nxt_state  = ST_IDLE;
        nxt_bypass = 1'b0;
      end
    end
    if (state == ST_BUSY && busy_cnt == '0) nxt_state = ret_state;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bypass      <= 1'b0;
      ers_chip_go <= 1'b0;
      ers_sect_go <= 1'b0;
      ers_addr    <= '0;
    end else begin
      state       <= nxt_state;
      bypass      <= nxt_bypass;
      ers_chip_go <= chip_n;
      ers_sect_go <= sect_n;
      if (chip_n || sect_n) ers_addr <= word_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_b7 <= 1'b0;
      status_b6 <= 1'b0;
      busy_cnt  <= '0;
    end else if (arr_we) begin
      status_b7 <= ~wdata[7];
      status_b6 <= 1'b0;
      busy_cnt  <= CNT_W'(BUSY_CYCLES - 1);
    end else if (state == ST_BUSY) begin
      if (bus_rd) status_b6 <= ~status_b6;
      if (busy_cnt == '0) status_b7 <= ~status_b7;
      else                busy_cnt  <= busy_cnt - 1'b1;
    end
  end

  AST_PROG_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> (state == ST_BUSY)); // R4

  AST_IDLE_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !bypass); // R2

  AST_UNLOCK_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && bus_wr && cmd != C_EXIT &&
     !(dec_addr == UNL0 && cmd == C_UNLOCK_A) &&
     !(dec_addr == QUERY_WADDR && cmd == C_QUERY)) |=> (state == ST_IDLE)); // R2

  AST_BYPASS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> ($past(bus_wr) && $past(cmd) == C_BYPASS)); // R6

  AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && bus_rd) |=> (status_b6 != $past(status_b6))); // R8

  AST_BUSY_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && busy_cnt == '0) |=> (state != ST_BUSY)); // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ers_chip_go, ers_sect_go})); // R11

endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
  import nor_seq_pkg::*;
#(
  parameter int          DW        = 16,
  parameter logic [15:0] ID0       = 16'h0001,
  parameter logic [15:0] ID1       = 16'h227E,
  parameter logic [15:0] ID2       = 16'h2210,
  parameter logic [15:0] ID3       = 16'h00FF,
  parameter int          QRY_LEN   = 64,
  parameter int          SIZE_LOG2 = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  seq_state_e    state,
  input  logic [10:0]   dec_addr,
  input  logic [DW-1:0] arr_rdata,
  input  logic          status_b7,
  input  logic          status_b6,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  localparam int IDW = (DW < 16) ? DW : 16;

  function automatic logic [DW-1:0] widen(input logic [15:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[IDW-1:0] = v[IDW-1:0];
    return r;
  endfunction

  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = arr_rdata;
    case (state)
      ST_BUSY: begin
        rd_next      = '0;
        rd_next[7:0] = {status_b7, ~status_b6, 6'b0};
      end
      ST_ID: begin
        case (dec_addr)
          11'h000: rd_next = widen(ID0);
          11'h001: rd_next = widen(ID1);
          11'h002: rd_next = '0;
          11'h00E: rd_next = (ID2 == 16'h00FF) ? arr_rdata : widen(ID2);
          11'h00F: rd_next = (ID3 == 16'h00FF) ? arr_rdata : widen(ID3);
          default: rd_next = arr_rdata;
        endcase
      end
      ST_QRY, ST_QRY_ID: begin
        rd_next      = '0;
        rd_next[7:0] = query_byte(dec_addr, QRY_LEN, SIZE_LOG2);
      end
      default: rd_next = arr_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_next;
    end
  end

  AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid); // R1

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          BUS_BYTES   = 2,
  parameter int          ADDR_W      = 13,
  parameter logic [15:0] UNLOCK0     = 16'h0555,
  parameter logic [15:0] UNLOCK1     = 16'h02AA,
  parameter logic [15:0] ID0         = 16'h0001,
  parameter logic [15:0] ID1         = 16'h227E,
  parameter logic [15:0] ID2         = 16'h2210,
  parameter logic [15:0] ID3         = 16'h00FF,
  parameter int          BUSY_CYCLES = 6,
  parameter int          QRY_LEN     = 64,
  localparam int         DW          = 8 * BUS_BYTES,
  localparam int         SHIFT       = (BUS_BYTES == 4) ? 2 : ((BUS_BYTES == 2) ? 1 : 0),
  localparam int         WADDR_W     = ADDR_W - SHIFT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  output logic [WADDR_W-1:0] arr_addr,
  input  logic [DW-1:0]      arr_rdata,
  output logic               arr_we,
  output logic [DW-1:0]      arr_wdata,
  input  logic               ers_busy,
  output logic               ers_chip_go,
  output logic               ers_sect_go,
  output logic [WADDR_W-1:0] ers_addr
);

  localparam int          CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [10:0] UNL0M = UNLOCK0[10:0];
  localparam logic [10:0] UNL1M = UNLOCK1[10:0];

  logic [WADDR_W-1:0] word_addr;
  logic [10:0]        dec_addr;
  seq_state_e         state;
  logic               bypass;
  logic               status_b7;
  logic               status_b6;

  assign arr_addr = word_addr;

  nor_addr_decode #(
    .ADDR_W (ADDR_W),
    .SHIFT  (SHIFT),
    .WADDR_W(WADDR_W)
  ) u_dec (
    .byte_addr(bus_addr),
    .word_addr(word_addr),
    .dec_addr (dec_addr)
  );

  nor_cmd_fsm #(
    .DW         (DW),
    .WADDR_W    (WADDR_W),
    .UNL0       (UNL0M),
    .UNL1       (UNL1M),
    .BUSY_CYCLES(BUSY_CYCLES),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .wdata      (bus_wdata),
    .dec_addr   (dec_addr),
    .word_addr  (word_addr),
    .arr_rdata  (arr_rdata),
    .ers_busy   (ers_busy),
    .state      (state),
    .bypass     (bypass),
    .status_b7  (status_b7),
    .status_b6  (status_b6),
    .arr_we     (arr_we),
    .arr_wdata  (arr_wdata),
    .ers_chip_go(ers_chip_go),
    .ers_sect_go(ers_sect_go),
    .ers_addr   (ers_addr)
  );

  nor_read_mux #(
    .DW       (DW),
    .ID0      (ID0),
    .ID1      (ID1),
    .ID2      (ID2),
    .ID3      (ID3),
    .QRY_LEN  (QRY_LEN),
    .SIZE_LOG2(ADDR_W)
  ) u_rmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .state    (state),
    .dec_addr (dec_addr),
    .arr_rdata(arr_rdata),
    .status_b7(status_b7),
    .status_b6(status_b6),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

  localparam int ADDR_W = 13;
  localparam int DW     = 16;
  localparam int WW     = 12;
  localparam int NWORDS = 4096;
  localparam int QLEN   = 64;
  localparam logic [15:0] ID0 = 16'h0001;
  localparam logic [15:0] ID1 = 16'h227E;
  localparam logic [15:0] ID2 = 16'h2210;
  localparam logic [15:0] ID3 = 16'h00FF;
  localparam int U0 = 'h555;
  localparam int U1 = 'h2AA;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DW-1:0]     rd_data;
  logic              rd_valid;
  logic [WW-1:0]     arr_addr;
  logic [DW-1:0]     arr_rdata;
  logic              arr_we;
  logic [DW-1:0]     arr_wdata;
  logic              ers_busy = 1'b0;
  logic              ers_chip_go;
  logic              ers_sect_go;
  logic [WW-1:0]     ers_addr;

  logic [DW-1:0] mem [NWORDS];
  logic [DW-1:0] shadow [NWORDS];
  int checks = 0;
  int errors = 0;
  int chip_cnt = 0;
  int sect_cnt = 0;
  logic [WW-1:0] last_ers = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] init_word(input int i);
    return 16'((i * 40503 + 12345) & 16'hFFFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= init_word(i);
    end else if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
    end
  end
  assign arr_rdata = mem[arr_addr];

  always @(posedge clk) begin
    if (rst_n && ers_sect_go) begin sect_cnt++; last_ers = ers_addr; end
    if (rst_n && ers_chip_go) chip_cnt++;
  end

  nor_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_data(rd_data), .rd_valid(rd_valid),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .ers_busy(ers_busy), .ers_chip_go(ers_chip_go),
    .ers_sect_go(ers_sect_go), .ers_addr(ers_addr)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input int w, input int d);
    @(negedge clk);
    bus_addr  = ADDR_W'(w * 2);
    bus_wdata = DW'(d);
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int w, output logic [DW-1:0] v);
    @(negedge clk);
    bus_addr = ADDR_W'(w * 2);
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(U0, 'hAA);
    wr(U1, 'h55);
  endtask

  task automatic expect_word(input string req, input int w);
    logic [DW-1:0] v;
    rd(w, v);
    chk(req, 32'(v), 32'(shadow[w]));
  endtask

  function automatic logic [7:0] qexp(input int idx);
    if (idx >= QLEN) return 8'h00;
    case (idx)
      'h10: return 8'h51;
      'h11: return 8'h52;
      'h12: return 8'h59;
      'h13: return 8'h02;
      'h27: return 8'(ADDR_W);
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic [DW-1:0] v;
    for (int i = 0; i < NWORDS; i++) shadow[i] = init_word(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state is array read; sweep of word addresses
    chk("R1 rd_valid idle", 32'(rd_valid), 0);
    for (int i = 0; i < 24; i++) begin
      int w;
      w = (i * 173) % NWORDS;
      rd(w, v);
      chk("R1 array read", 32'(v), 32'(shadow[w]));
      if (i == 0) chk("R1 rd_valid", 32'(rd_valid), 1);
    end

    // R4 / R8: program sweep with status reads
    for (int k = 0; k < 12; k++) begin
      int w;
      logic [DW-1:0] d;
      w = 16 + k * 7;
      d = DW'((k * 4369) ^ 16'h0F0F ^ (1 << k));
      unlock();
      wr(U0, 'hA0);
      wr(w, int'(d));
      rd(w, v);
      chk("R8 status first", 32'(v), 32'({~d[7], 1'b1, 6'b0}));
      rd(w, v);
      chk("R8 status second", 32'(v), 32'({~d[7], 1'b0, 6'b0}));
      idle(8);
      shadow[w] = shadow[w] & d;
      expect_word("R4 program AND", w);
    end
    // R4: programming all ones does not set bits
    unlock(); wr(U0, 'hA0); wr(16, 'hFFFF); idle(10);
    expect_word("R4 no bit set", 16);

    // R8: writes during busy are ignored
    unlock(); wr(U0, 'hA0); wr(200, 'h00FF); wr(200, 'h0000); idle(10);
    shadow[200] = shadow[200] & 16'h00FF;
    expect_word("R8 busy write ignored", 200);

    // R2: broken unlock at each point, then an attempted program
    for (int c = 0; c < 4; c++) begin
      int tw;
      tw = 300 + c;
      case (c)
        0: wr(U0 + 1, 'hAA);
        1: wr(U0, 'hAB);
        2: begin wr(U0, 'hAA); wr(U1 + 2, 'h55); end
        default: begin wr(U0, 'hAA); wr(U1, 'h54); end
      endcase
      wr(U0, 'hA0);
      wr(tw, 0);
      idle(8);
      expect_word("R2 broken unlock", tw);
    end

    // R3: command write off UNLOCK0, and unknown command
    unlock(); wr(U0 + 4, 'hA0); wr(310, 0); idle(8);
    expect_word("R3 cmd address", 310);
    unlock(); wr(U0, 'h55); wr(311, 0); idle(8);
    expect_word("R3 unknown cmd", 311);

    // R6: bypass programs, then exit via ID mode + 0x00
    unlock(); wr(U0, 'h20);
    for (int j = 0; j < 4; j++) begin
      wr('h123 + j, 'hA0);
      wr(400 + j, 'h5A5A >> j);
      idle(8);
      shadow[400 + j] = shadow[400 + j] & DW'('h5A5A >> j);
      expect_word("R6 bypass program", 400 + j);
    end
    wr(7, 'h90);
    rd(1, v);
    chk("R6 bypass ID read", 32'(v), 32'(ID1));
    wr(7, 'h00);
    wr(5, 'hA0); wr(410, 0); idle(8);
    expect_word("R6 bypass exit", 410);

    // R5: ID map sweep with aliases above bit 10
    unlock(); wr(U0, 'h90);
    for (int i = 0; i < 40; i++) begin
      int w;
      logic [DW-1:0] e;
      w = (i < 20) ? i : ('h800 + i - 20);
      case (w & 'h7FF)
        0: e = ID0;
        1: e = ID1;
        2: e = '0;
        'hE: e = ID2;
        default: e = shadow[w];
      endcase
      rd(w, v);
      chk("R5 ID map", 32'(v), 32'(e));
    end

    // R7: query from ID mode, then F0 back to ID (R9), F0 to array
    wr('h55, 'h98);
    for (int i = 0; i < QLEN + 8; i++) begin
      rd(i, v);
      chk("R7 query table", 32'(v), 32'(qexp(i)));
    end
    wr(0, 'hF0);
    rd(0, v);
    chk("R9 F0 back to ID", 32'(v), 32'(ID0));
    wr(0, 'hF0);
    expect_word("R9 F0 to array", 0);

    // R7 / R10: query from idle, any write leaves it
    wr('h55, 'h98);
    rd('h10, v);
    chk("R7 query from idle", 32'(v), 32'h51);
    wr('h300, 'h12);
    expect_word("R10 query write exit", 'h10);

    // R9: F0 as program data; F0 in command state
    unlock(); wr(U0, 'hA0); wr(500, 'hF0); idle(8);
    shadow[500] = shadow[500] & 16'h00F0;
    expect_word("R9 F0 as data", 500);
    unlock(); wr(U0, 'hF0); wr(U0, 'hA0); wr(501, 0); idle(8);
    expect_word("R9 F0 reset", 501);

    // R11: erase strobes
    unlock(); wr(U0, 'h80); unlock(); wr('h345, 'h30); idle(2);
    chk("R11 sector pulse", 32'(sect_cnt), 1);
    chk("R11 sector addr", 32'(last_ers), 32'h345);
    unlock(); wr(U0, 'h80); unlock(); wr(U0, 'h10); idle(2);
    chk("R11 chip pulse", 32'(chip_cnt), 1);
    unlock(); wr(U0, 'h80); unlock(); wr(U0 + 1, 'h10); idle(2);
    chk("R11 chip wrong addr", 32'(chip_cnt), 1);
    chk("R11 no sector", 32'(sect_cnt), 1);

    // R12: F0 ignored while erase busy
    ers_busy = 1'b1;
    unlock(); wr(U0, 'hF0); wr(U0, 'hA0); wr(600, 'h0F0F); idle(8);
    shadow[600] = shadow[600] & 16'h0F0F;
    expect_word("R12 F0 ignored busy", 600);
    ers_busy = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule